// File: doc/BRIEF.md
# System Control Instruction Executor

This block executes a group of 16-bit system-control instructions for a 32-bit RISC core. It copies control and system registers into a general register, and it stores them to memory after decrementing the address register by one word. It also sets the S and T status flags, raises a sleep request and starts a software trap that updates five registers at once. The control registers themselves live outside the block. Their current values arrive on input ports, and every change leaves the block as a write strobe with its data.

An instruction is presented on `instr_i` with `valid_i` high, together with the privilege bit `priv_i`. The block drives the read addresses of the Rn general register and the Rm bank register combinationally from the instruction word. The data returned on those read ports is used in the same cycle. All results are registered and appear for exactly one cycle, on the cycle after issue.

Top module: `sysctl_exec`

## Requirements
- R1: After reset, and until the first issued instruction has taken effect, every strobe output (`rf_we_o`, `mem_we_o`, `sr_we_o`, `ssr_we_o`, `spc_we_o`, `tra_we_o`, `expevt_we_o`, `pc_we_o`, `sleep_req_o`, `illegal_o`, `undef_o`) is low.
- R2: Word 0x0058 writes SR with bit 0 (S) set. Word 0x0018 writes SR with bit 1 (T) set. All other SR bits keep the value of `sr_i`. Neither instruction is privileged.
- R3: Word 0000nnnn ssss0010 writes the selected register to general register n. The selector ssss picks SR=0000, GBR=0001, VBR=0010, SSR=0011 and SPC=0100.
- R4: Word 0000nnnn ssss1010 writes the selected register to general register n. The selector picks MACH=0000, MACL=0001, PR=0010, SGR=0011 and DBR=1111.
- R5: Word 0000nnnn1mmm0010 writes bank register m to general register n. `bank_raddr_o` equals bits 6:4 of the word and `gpr_raddr_o` equals bits 11:8, combinationally.
- R6: Word 0100nnnn ssss0011 (selectors as in R3, plus 1mmm for bank m) and word 0100nnnn ssss0010 (selectors as in R4) each perform a pre-decrement store. In one cycle the block writes Rn−4 to general register n and raises a single-word memory write at address Rn−4 with the selected register as data.
- R7: Word 11000011iiiiiiii writes SPC=PC+2, SSR=SR, TRA=imm<<2, EXPEVT=0x160 and PC=VBR+0x100, all in the same cycle. It is not privileged.
- R8: The SR, VBR, SSR, SPC, SGR, DBR and bank accesses and SLEEP are privileged. If one of them is issued with `priv_i` low, the block raises `illegal_o` and makes no register, memory or sleep change. The GBR, MACH, MACL and PR accesses run in either mode.
- R9: A word matching none of the encodings above raises `undef_o` and makes no other change, in either mode.
- R10: Word 0x001B, issued in privileged mode, pulses `sleep_req_o` and changes nothing else.
- R11: Results appear on the cycle after the issue cycle and last one cycle. A cycle with `valid_i` low produces no strobe on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction issue |
| instr_i | input | 16 | Instruction word |
| priv_i | input | 1 | 1 = privileged mode |
| gpr_raddr_o | output | 4 | Rn read address |
| gpr_rdata_i | input | 32 | Rn read data |
| bank_raddr_o | output | 3 | Bank register read address |
| bank_rdata_i | input | 32 | Bank register read data |
| sr_i | input | 32 | Current SR |
| gbr_i | input | 32 | Current GBR |
| vbr_i | input | 32 | Current VBR |
| ssr_i | input | 32 | Current SSR |
| spc_i | input | 32 | Current SPC |
| sgr_i | input | 32 | Current SGR |
| dbr_i | input | 32 | Current DBR |
| mach_i | input | 32 | Current MACH |
| macl_i | input | 32 | Current MACL |
| pr_i | input | 32 | Current PR |
| pc_i | input | 32 | Address of the issued instruction |
| rf_we_o | output | 1 | General register write strobe |
| rf_waddr_o | output | 4 | General register write address |
| rf_wdata_o | output | 32 | General register write data |
| mem_we_o | output | 1 | Memory word write strobe |
| mem_addr_o | output | 32 | Memory write address |
| mem_wdata_o | output | 32 | Memory write data |
| sr_we_o | output | 1 | SR write strobe |
| sr_wdata_o | output | 32 | SR write data |
| ssr_we_o | output | 1 | SSR write strobe |
| ssr_wdata_o | output | 32 | SSR write data |
| spc_we_o | output | 1 | SPC write strobe |
| spc_wdata_o | output | 32 | SPC write data |
| tra_we_o | output | 1 | TRA write strobe |
| tra_wdata_o | output | 32 | TRA write data |
| expevt_we_o | output | 1 | EXPEVT write strobe |
| expevt_wdata_o | output | 32 | EXPEVT write data |
| pc_we_o | output | 1 | PC redirect strobe |
| pc_wdata_o | output | 32 | PC redirect target |
| sleep_req_o | output | 1 | Sleep request pulse |
| illegal_o | output | 1 | Privileged instruction in user mode |
| undef_o | output | 1 | Undefined instruction |

## Verification
A pre-decrement store drives two results in the same cycle. The general-register writeback of Rn−4 and the memory write to that same address must both appear in the cycle after issue. The bench provokes this with directed back-to-back stores, including one with Rn equal to zero so that the address wraps to 0xFFFFFFFC. It also mixes random stores into a stream of random words. Each store is judged by comparing both write ports against one reference value computed from the Rn data the bench supplied. The trap is judged the same way: all five of its strobes must rise together, each carrying its own expected value.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned GPR_AW  = 4;  // fixed by the encoding
  localparam int unsigned BANK_AW = 3;

  typedef enum logic [2:0] {
    OP_UNDEF, OP_SETS, OP_SETT, OP_SLEEP, OP_MOVE, OP_STORE, OP_TRAP
  } op_e;

  typedef enum logic [3:0] {
    SRC_SR, SRC_GBR, SRC_VBR, SRC_SSR, SRC_SPC, SRC_SGR,
    SRC_DBR, SRC_MACH, SRC_MACL, SRC_PR, SRC_BANK
  } src_e;

  typedef struct packed {
    op_e  op;
    src_e src;
    logic priv;
  } dec_t;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
(
  input  logic [15:0] instr_i,
  output dec_t        dec_o
);
  // control-register selector group (xxxx0010 / xxxx0011)
  function automatic dec_t grp_ctl(input logic [3:0] s);
    dec_t d;
    d = '{op: OP_MOVE, src: SRC_SR, priv: 1'b1};
    if (s[3])                d.src = SRC_BANK;
    else case (s[2:0])
      3'd0: d.src = SRC_SR;
      3'd1: begin d.src = SRC_GBR; d.priv = 1'b0; end
      3'd2: d.src = SRC_VBR;
      3'd3: d.src = SRC_SSR;
      3'd4: d.src = SRC_SPC;
      default: d.op = OP_UNDEF;
    endcase
    return d;
  endfunction

  // system-register selector group (xxxx1010 / 0100..xxxx0010)
  function automatic dec_t grp_sys(input logic [3:0] s);
    dec_t d;
    d = '{op: OP_MOVE, src: SRC_MACH, priv: 1'b0};
    case (s)
      4'h0: d.src = SRC_MACH;
      4'h1: d.src = SRC_MACL;
      4'h2: d.src = SRC_PR;
      4'h3: begin d.src = SRC_SGR; d.priv = 1'b1; end
      4'hF: begin d.src = SRC_DBR; d.priv = 1'b1; end
      default: d.op = OP_UNDEF;
    endcase
    return d;
  endfunction

  logic [3:0] hi, sub, lo;
  assign hi  = instr_i[15:12];
  assign sub = instr_i[7:4];
  assign lo  = instr_i[3:0];

  always_comb begin
    dec_o = '{op: OP_UNDEF, src: SRC_SR, priv: 1'b0};
    if (instr_i == 16'h0058)      dec_o.op = OP_SETS;
    else if (instr_i == 16'h0018) dec_o.op = OP_SETT;
    else if (instr_i == 16'h001B) begin dec_o.op = OP_SLEEP; dec_o.priv = 1'b1; end
    else if (instr_i[15:8] == 8'hC3) dec_o.op = OP_TRAP;
    else if (hi == 4'h0 && lo == 4'h2) dec_o = grp_ctl(sub);
    else if (hi == 4'h0 && lo == 4'hA) dec_o = grp_sys(sub);
    else if (hi == 4'h4 && lo == 4'h3) begin
      dec_o = grp_ctl(sub);
      if (dec_o.op == OP_MOVE) dec_o.op = OP_STORE;
    end
    else if (hi == 4'h4 && lo == 4'h2) begin
      dec_o = grp_sys(sub);
      if (dec_o.op == OP_MOVE) dec_o.op = OP_STORE;
    end
    if (dec_o.op == OP_UNDEF) dec_o.priv = 1'b0;
  end
endmodule

// File: rtl/sysctl_srcmux.sv
module sysctl_srcmux
  import sysctl_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  src_e            src_i,
  input  logic [XLEN-1:0] sr_i,
  input  logic [XLEN-1:0] gbr_i,
  input  logic [XLEN-1:0] vbr_i,
  input  logic [XLEN-1:0] ssr_i,
  input  logic [XLEN-1:0] spc_i,
  input  logic [XLEN-1:0] sgr_i,
  input  logic [XLEN-1:0] dbr_i,
  input  logic [XLEN-1:0] mach_i,
  input  logic [XLEN-1:0] macl_i,
  input  logic [XLEN-1:0] pr_i,
  input  logic [XLEN-1:0] bank_i,
  output logic [XLEN-1:0] data_o
);
  always_comb begin
    unique case (src_i)
      SRC_SR:   data_o = sr_i;
      SRC_GBR:  data_o = gbr_i;
      SRC_VBR:  data_o = vbr_i;
      SRC_SSR:  data_o = ssr_i;
      SRC_SPC:  data_o = spc_i;
      SRC_SGR:  data_o = sgr_i;
      SRC_DBR:  data_o = dbr_i;
      SRC_MACH: data_o = mach_i;
      SRC_MACL: data_o = macl_i;
      SRC_PR:   data_o = pr_i;
      SRC_BANK: data_o = bank_i;
      default:  data_o = '0;
    endcase
  end
endmodule

// File: rtl/sysctl_exec.sv
module sysctl_exec
  import sysctl_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned WORD_BYTES  = 4,
  parameter int unsigned TRAP_CODE   = 32'h160,
  parameter int unsigned TRAP_OFFSET = 32'h100,
  parameter int unsigned T_BIT       = 1,
  parameter int unsigned S_BIT       = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [15:0]        instr_i,
  input  logic               priv_i,
  output logic [GPR_AW-1:0]  gpr_raddr_o,
  input  logic [XLEN-1:0]    gpr_rdata_i,
  output logic [BANK_AW-1:0] bank_raddr_o,
  input  logic [XLEN-1:0]    bank_rdata_i,
  input  logic [XLEN-1:0]    sr_i,
  input  logic [XLEN-1:0]    gbr_i,
  input  logic [XLEN-1:0]    vbr_i,
  input  logic [XLEN-1:0]    ssr_i,
  input  logic [XLEN-1:0]    spc_i,
  input  logic [XLEN-1:0]    sgr_i,
  input  logic [XLEN-1:0]    dbr_i,
  input  logic [XLEN-1:0]    mach_i,
  input  logic [XLEN-1:0]    macl_i,
  input  logic [XLEN-1:0]    pr_i,
  input  logic [XLEN-1:0]    pc_i,
  output logic               rf_we_o,
  output logic [GPR_AW-1:0]  rf_waddr_o,
  output logic [XLEN-1:0]    rf_wdata_o,
  output logic               mem_we_o,
  output logic [XLEN-1:0]    mem_addr_o,
  output logic [XLEN-1:0]    mem_wdata_o,
  output logic               sr_we_o,
  output logic [XLEN-1:0]    sr_wdata_o,
  output logic               ssr_we_o,
  output logic [XLEN-1:0]    ssr_wdata_o,
  output logic               spc_we_o,
  output logic [XLEN-1:0]    spc_wdata_o,
  output logic               tra_we_o,
  output logic [XLEN-1:0]    tra_wdata_o,
  output logic               expevt_we_o,
  output logic [XLEN-1:0]    expevt_wdata_o,
  output logic               pc_we_o,
  output logic [XLEN-1:0]    pc_wdata_o,
  output logic               sleep_req_o,
  output logic               illegal_o,
  output logic               undef_o
);
  localparam logic [XLEN-1:0] STEP   = XLEN'(WORD_BYTES);
  localparam logic [XLEN-1:0] T_MASK = XLEN'(1) << T_BIT;
  localparam logic [XLEN-1:0] S_MASK = XLEN'(1) << S_BIT;

  dec_t            dec;
  logic [XLEN-1:0] src_data, dec_addr;
  logic            user_fault, exec;

  sysctl_decode i_decode (.instr_i(instr_i), .dec_o(dec));

  sysctl_srcmux #(.XLEN(XLEN)) i_srcmux (
    .src_i(dec.src), .sr_i(sr_i), .gbr_i(gbr_i), .vbr_i(vbr_i), .ssr_i(ssr_i),
    .spc_i(spc_i), .sgr_i(sgr_i), .dbr_i(dbr_i), .mach_i(mach_i),
    .macl_i(macl_i), .pr_i(pr_i), .bank_i(bank_rdata_i), .data_o(src_data)
  );

  assign gpr_raddr_o  = instr_i[11:8];
  assign bank_raddr_o = instr_i[6:4];
  assign dec_addr     = gpr_rdata_i - STEP;
  assign user_fault   = dec.priv && !priv_i;
  assign exec         = valid_i && dec.op != OP_UNDEF && !user_fault;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rf_we_o <= 1'b0; mem_we_o <= 1'b0; sr_we_o <= 1'b0; ssr_we_o <= 1'b0;
      spc_we_o <= 1'b0; tra_we_o <= 1'b0; expevt_we_o <= 1'b0; pc_we_o <= 1'b0;
      sleep_req_o <= 1'b0; illegal_o <= 1'b0; undef_o <= 1'b0;
      rf_waddr_o <= '0; rf_wdata_o <= '0; mem_addr_o <= '0; mem_wdata_o <= '0;
      sr_wdata_o <= '0; ssr_wdata_o <= '0; spc_wdata_o <= '0; tra_wdata_o <= '0;
      expevt_wdata_o <= '0; pc_wdata_o <= '0;
    end else begin
      undef_o     <= valid_i && dec.op == OP_UNDEF;
      illegal_o   <= valid_i && dec.op != OP_UNDEF && user_fault;
      rf_we_o     <= exec && (dec.op == OP_MOVE || dec.op == OP_STORE);
      mem_we_o    <= exec && dec.op == OP_STORE;
      sr_we_o     <= exec && (dec.op == OP_SETS || dec.op == OP_SETT);
      sleep_req_o <= exec && dec.op == OP_SLEEP;
      ssr_we_o    <= exec && dec.op == OP_TRAP;
      spc_we_o    <= exec && dec.op == OP_TRAP;
      tra_we_o    <= exec && dec.op == OP_TRAP;
      expevt_we_o <= exec && dec.op == OP_TRAP;
      pc_we_o     <= exec && dec.op == OP_TRAP;
      // data lanes are free-running; meaningful only under their strobe
      rf_waddr_o     <= instr_i[11:8];
      rf_wdata_o     <= (dec.op == OP_STORE) ? dec_addr : src_data;
      mem_addr_o     <= dec_addr;
      mem_wdata_o    <= src_data;
      sr_wdata_o     <= sr_i | ((dec.op == OP_SETT) ? T_MASK : S_MASK);
      ssr_wdata_o    <= sr_i;
      spc_wdata_o    <= pc_i + XLEN'(2);
      tra_wdata_o    <= XLEN'({instr_i[7:0], 2'b00});
      expevt_wdata_o <= XLEN'(TRAP_CODE);
      pc_wdata_o     <= vbr_i + XLEN'(TRAP_OFFSET);
    end
  end

  logic any_effect;
  assign any_effect = rf_we_o || mem_we_o || sr_we_o || ssr_we_o || spc_we_o ||
                      tra_we_o || expevt_we_o || pc_we_o || sleep_req_o;

  AST_STORE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> rf_we_o && rf_wdata_o == mem_addr_o); // R6
  AST_STORE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o == $past(gpr_rdata_i) - STEP); // R6
  AST_TRAP_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |-> spc_we_o && ssr_we_o && tra_we_o && expevt_we_o); // R7
  AST_TRAP_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |-> pc_wdata_o == $past(vbr_i) + XLEN'(TRAP_OFFSET)); // R7
  AST_FLAG_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_we_o |-> $countones(sr_wdata_o ^ $past(sr_i)) <= 1); // R2
  AST_USER_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !$past(priv_i) && !any_effect); // R8
  AST_UNDEF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> !any_effect && !illegal_o); // R9
  AST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> !any_effect && !illegal_o && !undef_o); // R11
endmodule

// File: tb/test_sysctl_exec.sv
module test_sysctl_exec;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic        priv_i = 1'b0;
  logic [3:0]  gpr_raddr_o;
  logic [31:0] gpr_rdata_i = '0;
  logic [2:0]  bank_raddr_o;
  logic [31:0] bank_rdata_i;
  logic [31:0] sr_i = '0, gbr_i = '0, vbr_i = '0, ssr_i = '0, spc_i = '0, sgr_i = '0;
  logic [31:0] dbr_i = '0, mach_i = '0, macl_i = '0, pr_i = '0, pc_i = '0;
  logic        rf_we_o, mem_we_o, sr_we_o, ssr_we_o, spc_we_o, tra_we_o;
  logic        expevt_we_o, pc_we_o, sleep_req_o, illegal_o, undef_o;
  logic [3:0]  rf_waddr_o;
  logic [31:0] rf_wdata_o, mem_addr_o, mem_wdata_o, sr_wdata_o, ssr_wdata_o;
  logic [31:0] spc_wdata_o, tra_wdata_o, expevt_wdata_o, pc_wdata_o;
  logic [31:0] bank_vals [8];

  always #5 clk_i = ~clk_i;
  assign bank_rdata_i = bank_vals[bank_raddr_o];

  sysctl_exec i_sysctl_exec (.*);

  int checks = 0, fails = 0;
  bit done = 1'b0;

  localparam int K_UNDEF = 0, K_SETS = 1, K_SETT = 2, K_SLEEP = 3;
  localparam int K_MOVE = 4, K_STORE = 5, K_TRAP = 6;

  // expected outputs
  logic [10:0] e_stb;
  logic [31:0] e_rf, e_addr, e_mdata, e_sr, e_ssr, e_spc, e_tra, e_pc;
  logic [3:0]  e_waddr;
  string       tag;

  task automatic chk(input string t, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", t, what, got, exp);
    end
  endtask

  function automatic logic [10:0] strobes();
    return {rf_we_o, mem_we_o, sr_we_o, ssr_we_o, spc_we_o, tra_we_o,
            expevt_we_o, pc_we_o, sleep_req_o, illegal_o, undef_o};
  endfunction

  task automatic randomize_regs();
    sr_i = $urandom; gbr_i = $urandom; vbr_i = $urandom; ssr_i = $urandom;
    spc_i = $urandom; sgr_i = $urandom; dbr_i = $urandom; mach_i = $urandom;
    macl_i = $urandom; pr_i = $urandom; pc_i = $urandom; gpr_rdata_i = $urandom;
    for (int b = 0; b < 8; b++) bank_vals[b] = $urandom;
  endtask

  // reference model built from the requirement text
  task automatic model(input logic [15:0] w, input logic pv);
    int kind; bit pr; logic [31:0] v; bit ill, ex;
    logic [3:0] hi, sub, lo;
    hi = w[15:12]; sub = w[7:4]; lo = w[3:0];
    kind = K_UNDEF; pr = 0; v = '0; tag = "R9";
    if (w == 16'h0058) begin kind = K_SETS; tag = "R2"; end
    else if (w == 16'h0018) begin kind = K_SETT; tag = "R2"; end
    else if (w == 16'h001B) begin kind = K_SLEEP; pr = 1; tag = "R10"; end
    else if (w[15:8] == 8'hC3) begin kind = K_TRAP; tag = "R7"; end
    else if ((hi == 0 && lo == 4'h2) || (hi == 4 && lo == 4'h3)) begin
      kind = (hi == 0) ? K_MOVE : K_STORE; pr = 1; tag = (hi == 0) ? "R3" : "R6";
      if (sub[3]) begin v = bank_vals[sub[2:0]]; if (hi == 0) tag = "R5"; end
      else case (sub)
        4'd0: v = sr_i;
        4'd1: begin v = gbr_i; pr = 0; end
        4'd2: v = vbr_i;
        4'd3: v = ssr_i;
        4'd4: v = spc_i;
        default: begin kind = K_UNDEF; pr = 0; tag = "R9"; end
      endcase
    end
    else if ((hi == 0 && lo == 4'hA) || (hi == 4 && lo == 4'h2)) begin
      kind = (hi == 0) ? K_MOVE : K_STORE; tag = (hi == 0) ? "R4" : "R6";
      case (sub)
        4'h0: v = mach_i;
        4'h1: v = macl_i;
        4'h2: v = pr_i;
        4'h3: begin v = sgr_i; pr = 1; end
        4'hF: begin v = dbr_i; pr = 1; end
        default: begin kind = K_UNDEF; tag = "R9"; end
      endcase
    end
    ill = pr && !pv && kind != K_UNDEF;
    if (ill) tag = "R8";
    ex = kind != K_UNDEF && !ill;
    e_stb = {ex && (kind == K_MOVE || kind == K_STORE), ex && kind == K_STORE,
             ex && (kind == K_SETS || kind == K_SETT), {5{ex && kind == K_TRAP}},
             ex && kind == K_SLEEP, ill, kind == K_UNDEF};
    e_waddr = w[11:8];
    e_addr  = gpr_rdata_i - 32'd4;
    e_rf    = (kind == K_STORE) ? e_addr : v;
    e_mdata = v;
    e_sr    = sr_i | ((kind == K_SETT) ? 32'd2 : 32'd1);
    e_ssr   = sr_i; e_spc = pc_i + 32'd2;
    e_tra   = {22'd0, w[7:0], 2'b00}; e_pc = vbr_i + 32'h100;
  endtask

  task automatic issue(input logic [15:0] w, input logic pv, input bit fixed_regs = 0);
    @(negedge clk_i);
    if (!fixed_regs) randomize_regs();
    instr_i = w; priv_i = pv; valid_i = 1'b1;
    model(w, pv);
    #1;
    chk("R5", "gpr_raddr", 32'(gpr_raddr_o), 32'(w[11:8]));
    chk("R5", "bank_raddr", 32'(bank_raddr_o), 32'(w[6:4]));
    @(posedge clk_i); #2;
    chk(tag, "strobes", 32'(strobes()), 32'(e_stb));
    if (e_stb[10]) begin
      chk(tag, "rf_waddr", 32'(rf_waddr_o), 32'(e_waddr));
      chk(tag, "rf_wdata", rf_wdata_o, e_rf);
    end
    if (e_stb[9]) begin
      chk("R6", "mem_addr", mem_addr_o, e_addr);
      chk("R6", "mem_wdata", mem_wdata_o, e_mdata);
    end
    if (e_stb[8]) chk("R2", "sr_wdata", sr_wdata_o, e_sr);
    if (e_stb[7]) begin
      chk("R7", "ssr", ssr_wdata_o, e_ssr);
      chk("R7", "spc", spc_wdata_o, e_spc);
      chk("R7", "tra", tra_wdata_o, e_tra);
      chk("R7", "expevt", expevt_wdata_o, 32'h160);
      chk("R7", "pc", pc_wdata_o, e_pc);
    end
  endtask

  task automatic idle();
    @(negedge clk_i); valid_i = 1'b0; instr_i = 16'h0058; priv_i = 1'b1;
    @(posedge clk_i); #2;
    chk("R11", "idle strobes", 32'(strobes()), 32'd0);
  endtask

  function automatic logic [15:0] rnd_word();
    logic [3:0] n; logic [3:0] s; int pick;
    n = 4'($urandom); s = 4'($urandom); pick = int'($urandom % 10);
    case (pick)
      0: return {4'h0, n, s, 4'h2};
      1: return {4'h0, n, s, 4'hA};
      2: return {4'h4, n, s, 4'h3};
      3: return {4'h4, n, s, 4'h2};
      4: return {8'hC3, 8'($urandom)};
      5: return 16'h0058;
      6: return 16'h0018;
      7: return 16'h001B;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    for (int b = 0; b < 8; b++) bank_vals[b] = '0;
    repeat (3) @(posedge clk_i);
    #2 chk("R1", "reset strobes", 32'(strobes()), 32'd0);
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #2 chk("R1", "post-reset strobes", 32'(strobes()), 32'd0);

    // directed
    issue(16'h0058, 1'b0);            // R2 S in user mode
    issue(16'h0018, 1'b0);            // R2 T
    issue(16'h001B, 1'b1);            // R10
    issue(16'h001B, 1'b0);            // R8 sleep in user mode
    for (int s = 0; s < 5; s++) issue({8'h05, 4'(s), 4'h2}, 1'b1);    // R3
    issue(16'h0712, 1'b0);            // GBR in user mode, R3
    issue(16'h0302, 1'b0);            // R8
    for (int s = 0; s < 4; s++) issue({8'h09, 4'(s), 4'hA}, 1'b1);    // R4
    issue(16'h09FA, 1'b1);            // R4 DBR
    issue(16'h09FA, 1'b0);            // R8 DBR user
    for (int m = 0; m < 8; m++) issue({8'h0C, 1'b1, 3'(m), 4'h2}, 1'b1); // R5
    issue(16'h0052, 1'b1);            // R9 gap code
    issue(16'h045A, 1'b1);            // R9
    issue(16'hFFFF, 1'b0);            // R9
    issue(16'hC3FF, 1'b0);            // R7 max imm, user mode
    issue(16'hC300, 1'b1);            // R7
    // back-to-back stores incl. address wrap, R6
    @(negedge clk_i); randomize_regs(); gpr_rdata_i = 32'd0;
    issue(16'h42F3, 1'b1, 1);
    issue(16'h4A02, 1'b0);
    issue(16'h41F2, 1'b1);
    issue(16'h41F2, 1'b0);            // R8 store DBR user
    idle(); idle();                   // R11
    issue(16'h4123, 1'b1);

    // random mix
    for (int i = 0; i < 600; i++) begin
      issue(rnd_word(), ($urandom % 4) != 0);
      if (($urandom % 16) == 0) idle();
    end
    idle();

    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule